// File: doc/BRIEF.md
# LED and Button Register Slave (AXI4-Lite)

This block is a small AXI4-Lite target that gives a processor four 32-bit registers. One register drives an 8-bit LED bank. A second register reports the state of a push-button. The remaining two registers are general scratch storage that software may use freely. The register index comes from address bits [3:2], so the registers sit at byte offsets 0x0 (LED control), 0x4 (button status), 0x8 and 0xC (scratch).

The write path waits until the master presents address and data together. It then raises both ready signals in the same single cycle, stores the data at the handshake, and holds a write response until the master takes it. The read path answers a read address with a one-cycle ready pulse and returns a registered data beat that holds until the master accepts it. Each slave handles one transaction per direction at a time. The button input is taken as already synchronous and debounced. All responses report OKAY.

Top module: `lite_led_regs`

## Requirements
- R1: While `rst` is high and after it falls, every ready and valid output is low, `led` is 0, and the writable registers (index 0, 2, 3) read back 0. A later reset clears them again.
- R2: `s_awready` and `s_wready` rise together, one cycle after `s_awvalid` and `s_wvalid` are both seen high, and stay high for exactly one cycle.
- R3: The cycle after the write handshake, `s_bvalid` is high with `s_bresp` = 2'b00. It stays high until a cycle with `s_bready` high, then drops.
- R4: One cycle after `s_arvalid` is seen, `s_arready` is high for exactly one cycle.
- R5: The cycle after the read handshake, `s_rvalid` is high with `s_rresp` = 2'b00. `s_rvalid` and `s_rdata` hold until a cycle with `s_rready` high, then `s_rvalid` drops.
- R6: `led` equals bits [7:0] of register index 0 (offset 0x0). Writing 1 there makes `led` = 8'h01 right after the handshake.
- R7: Register index 1 (offset 0x4) reads 32'hFFFF_FFFF while `btn_pressed` is 1 and 0 while it is 0. A write to it changes no register and does not change `led`.
- R8: Registers index 2 and 3 (offsets 0x8, 0xC) return the last value written to them. The index is taken from address bits [3:2].
- R9: Each `s_wstrb` bit n enables the write of byte lane n (bits 8n+7:8n) of the addressed writable register. A write with all strobes low leaves the register unchanged.
- R10: While `s_bvalid` is pending, no new write is accepted (`s_awready` stays low). While `s_rvalid` is pending, no new read is accepted (`s_arready` stays low).
- R11: An address without data (or data without an address) is never accepted. The ready outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_awaddr | input | 4 | Write byte address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte enables |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 4 | Read byte address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| btn_pressed | input | 1 | Synchronous button level, 1 = pressed |
| led | output | 8 | LED drive, low byte of register 0 |

## Verification
The bench holds the response channels back for several cycles. A slave that drops a valid early, or that lets read data drift, loses a beat or returns the wrong data. It offers a second transaction while a response is still pending and an address without its data. A slave that gates acceptance wrongly would take that write, and a later readback of the scratch register would show the change. Partial and empty byte strobes catch a slave that writes whole words. Writes to the button register, made with the button pressed and released, catch a slave that stores into that register or aliases it onto the LED register. A second reset checks that stored values are cleared.

// File: rtl/lite_led_pkg.sv
package lite_led_pkg;
  localparam int NREG   = 4;
  localparam int IDX_W  = $clog2(NREG);
  localparam int ADDR_W = IDX_W + 2;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  typedef enum logic [IDX_W-1:0] {
    REG_LED       = 2'd0,
    REG_BTN       = 2'd1,
    REG_SCRATCH_A = 2'd2,
    REG_SCRATCH_B = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/lite_wr_path.sv
module lite_wr_path (
  input  logic clk,
  input  logic rst,
  input  logic awvalid,
  input  logic wvalid,
  input  logic bready,
  output logic aw_w_ready,
  output logic bvalid,
  output logic wr_fire
);
  logic acc_q;
  logic bvalid_q;

  // ready is offered only when both channels present and nothing is pending
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= 1'b0;
      bvalid_q <= 1'b0;
    end else begin
      acc_q <= awvalid && wvalid && !acc_q && !bvalid_q;
      if (wr_fire)     bvalid_q <= 1'b1;
      else if (bready) bvalid_q <= 1'b0;
    end
  end

  assign wr_fire    = acc_q && awvalid && wvalid;
  assign aw_w_ready = acc_q;
  assign bvalid     = bvalid_q;

  AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    acc_q |=> !acc_q); // R2
  AST_READY_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
    $rose(acc_q) |-> $past(awvalid && wvalid)); // R11
  AST_BVALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    bvalid_q && !bready |=> bvalid_q); // R3
  AST_NO_WRITE_PENDING: assert property (@(posedge clk) disable iff (rst)
    bvalid_q |-> !acc_q); // R10
endmodule

// File: rtl/lite_rd_path.sv
module lite_rd_path #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arvalid,
  input  logic              rready,
  input  logic [DATA_W-1:0] sel_data,
  output logic              arready,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata
);
  logic              arready_q;
  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rd_fire;

  assign rd_fire = arvalid && arready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      arready_q <= 1'b0;
      rvalid_q  <= 1'b0;
      rdata_q   <= '0;
    end else begin
      arready_q <= arvalid && !arready_q && !rvalid_q;
      if (rd_fire) begin
        rvalid_q <= 1'b1;
        rdata_q  <= sel_data;
      end else if (rready) begin
        rvalid_q <= 1'b0;
      end
    end
  end

  assign arready = arready_q;
  assign rvalid  = rvalid_q;
  assign rdata   = rdata_q;

  AST_ARREADY_PULSE: assert property (@(posedge clk) disable iff (rst)
    arready_q |=> !arready_q); // R4
  AST_RVALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    rvalid_q && !rready |=> rvalid_q && $stable(rdata_q)); // R5
  AST_NO_READ_PENDING: assert property (@(posedge clk) disable iff (rst)
    rvalid_q |-> !arready_q); // R10
endmodule

// File: rtl/lite_led_regfile.sv
module lite_led_regfile
  import lite_led_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LED_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  reg_idx_e            wr_idx,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [DATA_W/8-1:0] wr_strb,
  input  reg_idx_e            rd_idx,
  input  logic                btn_pressed,
  output logic [DATA_W-1:0]   rd_data,
  output logic [LED_W-1:0]    led
);
  localparam int STRB_W = DATA_W / 8;

  logic [NREG-1:0][DATA_W-1:0] view;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    if (r == int'(REG_BTN)) begin : g_status
      assign view[r] = {DATA_W{btn_pressed}};
    end else begin : g_store
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) begin
          q <= '0;
        end else if (wr_en && int'(wr_idx) == r) begin
          for (int b = 0; b < STRB_W; b++)
            if (wr_strb[b]) q[b*8 +: 8] <= wr_data[b*8 +: 8];
        end
      end
      assign view[r] = q;
    end
  end

  assign rd_data = view[rd_idx];
  assign led     = view[REG_LED][LED_W-1:0];

  AST_LED_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_idx == REG_LED && (&wr_strb) |=> led == $past(wr_data[LED_W-1:0])); // R6
  AST_LED_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_idx == REG_LED) |=> $stable(led)); // R7
endmodule

// File: rtl/lite_led_regs.sv
module lite_led_regs
  import lite_led_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LED_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   s_awaddr,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [DATA_W-1:0]   s_wdata,
  input  logic [DATA_W/8-1:0] s_wstrb,
  input  logic                s_wvalid,
  output logic                s_wready,
  output logic [1:0]          s_bresp,
  output logic                s_bvalid,
  input  logic                s_bready,
  input  logic [ADDR_W-1:0]   s_araddr,
  input  logic                s_arvalid,
  output logic                s_arready,
  output logic [DATA_W-1:0]   s_rdata,
  output logic [1:0]          s_rresp,
  output logic                s_rvalid,
  input  logic                s_rready,
  input  logic                btn_pressed,
  output logic [LED_W-1:0]    led
);
  logic        wr_fire;
  logic        aw_w_ready;
  reg_idx_e    wr_idx;
  reg_idx_e    rd_idx;
  logic [DATA_W-1:0] sel_data;
  logic        unused_low_addr;

  // byte offset within a word carries no meaning here
  assign unused_low_addr = ^{s_awaddr[1:0], s_araddr[1:0]};
  assign wr_idx = reg_idx_e'(s_awaddr[ADDR_W-1:2]);
  assign rd_idx = reg_idx_e'(s_araddr[ADDR_W-1:2]);

  lite_wr_path i_wr (
    .clk        (clk),
    .rst        (rst),
    .awvalid    (s_awvalid),
    .wvalid     (s_wvalid),
    .bready     (s_bready),
    .aw_w_ready (aw_w_ready),
    .bvalid     (s_bvalid),
    .wr_fire    (wr_fire)
  );

  lite_rd_path #(.DATA_W(DATA_W)) i_rd (
    .clk      (clk),
    .rst      (rst),
    .arvalid  (s_arvalid),
    .rready   (s_rready),
    .sel_data (sel_data),
    .arready  (s_arready),
    .rvalid   (s_rvalid),
    .rdata    (s_rdata)
  );

  lite_led_regfile #(.DATA_W(DATA_W), .LED_W(LED_W)) i_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_fire),
    .wr_idx      (wr_idx),
    .wr_data     (s_wdata),
    .wr_strb     (s_wstrb),
    .rd_idx      (rd_idx),
    .btn_pressed (btn_pressed),
    .rd_data     (sel_data),
    .led         (led)
  );

  assign s_awready = aw_w_ready;
  assign s_wready  = aw_w_ready;
  assign s_bresp   = RESP_OKAY;
  assign s_rresp   = RESP_OKAY;

  AST_BVALID_AFTER_FIRE: assert property (@(posedge clk) disable iff (rst)
    s_awvalid && s_awready && s_wvalid && s_wready |=> s_bvalid); // R3
  AST_RVALID_AFTER_AR: assert property (@(posedge clk) disable iff (rst)
    s_arvalid && s_arready |=> s_rvalid); // R5
endmodule

// File: tb/test_lite_led_regs.sv
`timescale 1ns/100ps
module test_lite_led_regs;
  localparam int DATA_W = 32;
  localparam int LED_W  = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  awaddr = '0, araddr = '0;
  logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic        btn = 0;
  logic        awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;
  logic [7:0]  led;

  always #2.5 clk = ~clk;

  lite_led_regs #(.DATA_W(DATA_W), .LED_W(LED_W)) i_lite_led_regs (
    .clk(clk), .rst(rst),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
    .btn_pressed(btn), .led(led)
  );

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct { logic [31:0] d; string req; } exp_t;
  exp_t        exp_q[$];
  logic [31:0] model [4];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] s);
    for (int b = 0; b < 4; b++) if (s[b]) old[b*8 +: 8] = nw[b*8 +: 8];
    return old;
  endfunction

  // scoreboard monitor: compares each accepted read beat with the queue head
  always @(negedge clk) begin
    if (!rst && rvalid && rready) begin
      if (exp_q.size() == 0) begin
        chk("R5", "unexpected read beat", rdata, 32'hxxxx_xxxx);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.req, "read data", rdata, e.d);
        chk("R5", "rresp", 32'(rresp), 32'd0);
      end
    end
  end

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic do_write(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s, input int bdel);
    step();
    awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
    @(negedge clk); chk("R2", "ready too early", 32'(awready), 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R2", "awready after both valid", 32'(awready), 32'd1);
    chk("R2", "wready with awready", 32'(wready), 32'd1);
    step();
    awvalid = 0; wvalid = 0;
    if (a[3:2] != 2'd1) model[a[3:2]] = merge(model[a[3:2]], d, s);
    @(negedge clk);
    chk("R3", "bvalid after handshake", 32'(bvalid), 32'd1);
    chk("R3", "bresp okay", 32'(bresp), 32'd0);
    chk("R2", "ready single cycle", 32'(awready), 32'd0);
    for (int i = 0; i < bdel; i++) begin
      step(); @(negedge clk);
      chk("R3", "bvalid held", 32'(bvalid), 32'd1);
    end
    step(); bready = 1;
    step(); bready = 0;
    @(negedge clk); chk("R3", "bvalid cleared", 32'(bvalid), 32'd0);
  endtask

  task automatic do_read(input logic [3:0] a, input logic [31:0] e, input string req, input int rdel);
    exp_q.push_back('{e, req});
    step();
    araddr = a; arvalid = 1;
    @(negedge clk); chk("R4", "arready too early", 32'(arready), 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R4", "arready pulse", 32'(arready), 32'd1);
    step();
    arvalid = 0;
    @(negedge clk);
    chk("R4", "arready one cycle", 32'(arready), 32'd0);
    chk("R5", "rvalid after handshake", 32'(rvalid), 32'd1);
    for (int i = 0; i < rdel; i++) begin
      step(); @(negedge clk);
      chk("R5", "rvalid held", 32'(rvalid), 32'd1);
    end
    step(); rready = 1;
    step(); rready = 0;
    @(negedge clk); chk("R5", "rvalid cleared", 32'(rvalid), 32'd0);
  endtask

  initial begin
    #1_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1", "awready in reset", 32'(awready), 32'd0);
    chk("R1", "bvalid in reset", 32'(bvalid), 32'd0);
    chk("R1", "arready in reset", 32'(arready), 32'd0);
    chk("R1", "rvalid in reset", 32'(rvalid), 32'd0);
    chk("R1", "led in reset", 32'(led), 32'd0);
    step(); rst = 0;
    do_read(4'h0, 32'd0, "R1", 0);
    do_read(4'h8, 32'd0, "R1", 0);
    do_read(4'hC, 32'd0, "R1", 1);

    // R6: LED register
    do_write(4'h0, 32'd1, 4'hF, 0);
    @(negedge clk); chk("R6", "led after writing 1", 32'(led), 32'h01);
    do_read(4'h0, 32'd1, "R6", 0);
    do_write(4'h0, 32'hA5C3_5A3C, 4'hF, 2);
    @(negedge clk); chk("R6", "led low byte", 32'(led), 32'h3C);

    // R8: scratch registers
    do_write(4'h8, 32'hDEAD_BEEF, 4'hF, 3);
    do_write(4'hC, 32'h1234_5678, 4'hF, 0);
    do_read(4'h8, 32'hDEAD_BEEF, "R8", 2);
    do_read(4'hC, 32'h1234_5678, "R8", 0);

    // R9: byte strobes
    do_write(4'h8, 32'h1122_3344, 4'b0101, 0);
    do_read(4'h8, 32'hDE22_BE44, "R9", 0);
    do_write(4'hC, 32'hFFFF_FFFF, 4'b0000, 1);
    do_read(4'hC, 32'h1234_5678, "R9", 0);
    do_write(4'h0, 32'h0000_7700, 4'b0010, 0);
    do_read(4'h0, 32'hA5C3_773C, "R9", 0);

    // R7: button status register
    btn = 0;
    do_read(4'h4, 32'd0, "R7", 0);
    btn = 1;
    do_read(4'h4, 32'hFFFF_FFFF, "R7", 1);
    do_write(4'h4, 32'h0000_0000, 4'hF, 0);
    do_read(4'h4, 32'hFFFF_FFFF, "R7", 0);
    @(negedge clk); chk("R7", "led unchanged by status write", 32'(led), 32'h3C);
    btn = 0;
    do_write(4'h4, 32'hFFFF_FFFF, 4'hF, 0);
    do_read(4'h4, 32'd0, "R7", 0);
    do_read(4'h0, model[0], "R7", 0);

    // R11: one channel alone is never accepted
    step(); awaddr = 4'h8; wdata = 32'h0BAD_0BAD; wstrb = 4'hF; awvalid = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); chk("R11", "awready with address only", 32'(awready), 32'd0);
      step();
    end
    awvalid = 0; wvalid = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); chk("R11", "wready with data only", 32'(wready), 32'd0);
      step();
    end
    wvalid = 0;
    do_read(4'h8, model[2], "R11", 0);

    // R10: no new write while response pending
    step(); awaddr = 4'hC; wdata = 32'hCAFE_F00D; wstrb = 4'hF; awvalid = 1; wvalid = 1;
    @(posedge clk); @(posedge clk); #1;
    awvalid = 0; wvalid = 0;
    model[3] = 32'hCAFE_F00D;
    @(negedge clk); chk("R10", "first write response", 32'(bvalid), 32'd1);
    step(); awaddr = 4'hC; wdata = 32'h0000_0001; awvalid = 1; wvalid = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); chk("R10", "awready while bvalid pending", 32'(awready), 32'd0);
      step();
    end
    awvalid = 0; wvalid = 0; bready = 1;
    step(); bready = 0;
    @(negedge clk); chk("R10", "bvalid cleared", 32'(bvalid), 32'd0);
    do_read(4'hC, 32'hCAFE_F00D, "R10", 0);

    // R10: no new read while data pending
    exp_q.push_back('{model[2], "R10"});
    step(); araddr = 4'h8; arvalid = 1;
    @(posedge clk); @(posedge clk); #1;
    arvalid = 0;
    @(negedge clk); chk("R10", "first read data", 32'(rvalid), 32'd1);
    step(); araddr = 4'hC; arvalid = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); chk("R10", "arready while rvalid pending", 32'(arready), 32'd0);
      step();
    end
    arvalid = 0; rready = 1;
    step(); rready = 0;
    @(negedge clk); chk("R10", "rvalid cleared", 32'(rvalid), 32'd0);
    chk("R10", "no extra beat queued", 32'(exp_q.size()), 32'd0);

    // R1: second reset clears stored values
    step(); rst = 1;
    step(); step(); rst = 0;
    for (int i = 0; i < 4; i++) model[i] = '0;
    @(negedge clk); chk("R1", "led after reset", 32'(led), 32'd0);
    do_read(4'h8, 32'd0, "R1", 0);
    do_read(4'h0, 32'd0, "R1", 0);

    repeat (3) step();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule